// File: doc/BRIEF.md
# Stallable Pipeline Stage Register Bank

This block is one stage register of a processor-style pipeline. It holds a group of fields, and each field has its own width and its own flush constant. All fields share one clock and two control lines. At every rising clock edge the bank does exactly one of three things:

- **Load:** it takes the values on its inputs.
- **Hold:** it keeps what it already has (stall).
- **Flush:** it forces every field to its own flush constant (bubble). This lets hazard logic outside the block insert an empty slot that is not all zeros.

The fields are given by three parameters:

- a field count;
- a vector of 8-bit field widths;
- a vector of 32-bit flush constants.

All fields travel on one packed input bus and one packed output bus. Field 0 sits at the least significant end of each bus. The outputs come straight from flip-flops.

Top module: `pipe_stage_bank`

## Requirements
- R1: With default parameters the bank carries three fields packed low-first on both buses: field 0 is 3 bits at [2:0], field 1 is 5 bits at [7:3], field 2 is 8 bits at [15:8]; each field loads independently of the others.
- R2: The default flush constants are 2 for field 0, 0 for field 1 and 8'hA5 for field 2, so a flushed bus reads 16'hA502.
- R3: When `bubble_i` is 1 at a rising edge, every field takes its flush constant at that edge and the input bus has no effect.
- R4: When `stall_i` is 1 and `bubble_i` is 0 at a rising edge, the output bus keeps its value and the input bus has no effect.
- R5: When both `stall_i` and `bubble_i` are 0 at a rising edge, the output bus takes the value of the input bus at that edge.
- R6: When `stall_i` and `bubble_i` are both 1, the flush wins: the output becomes the flush constants.
- R7: When `rst` is 1 at a rising edge, all fields take their flush constants, whatever the controls and inputs are.
- R8: The output bus changes only at rising clock edges; a change of the input bus between edges does not reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the flush constants |
| stall_i | input | 1 | Hold request: keep the current field values |
| bubble_i | input | 1 | Flush request: load every field with its flush constant |
| fields_i | input | TOTAL_W (16) | Packed next values of all fields, field 0 at bit 0 |
| fields_o | output | TOTAL_W (16) | Packed registered values of all fields, field 0 at bit 0 |

## Verification
The assertions take for granted that `rst`, `stall_i` and `bubble_i` carry known 0/1 values at every rising edge. They also take for granted that `fields_i` is fully driven whenever a load can occur, because the load check compares the output with the input sampled one edge earlier.

The bench changes every input only at falling edges, or a short time after a rising edge. Every input is always given a defined value, and X is never left on a control line. The only input change made between edges is the deliberate R8 disturbance of the data bus, which leaves the controls alone.

// File: rtl/pipe_bank_pkg.sv
package pipe_bank_pkg;

    // Largest number of fields the packed parameter vectors can describe
    localparam int unsigned MAX_FIELDS = 16;
    localparam int unsigned WSLOT_W    = 8;
    localparam int unsigned BSLOT_W    = 32;
    localparam int unsigned WVEC_W     = MAX_FIELDS * WSLOT_W;
    localparam int unsigned BVEC_W     = MAX_FIELDS * BSLOT_W;

    // What the stage does at the next edge
    typedef enum logic [1:0] {
        ACT_LOAD  = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_FLUSH = 2'd2
    } act_e;

    function automatic int unsigned field_width(logic [WVEC_W-1:0] ws, int unsigned idx);
        return 32'(ws[idx*WSLOT_W +: WSLOT_W]);
    endfunction

    function automatic int unsigned field_offset(logic [WVEC_W-1:0] ws, int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < MAX_FIELDS; i++) begin
            if (i < idx) acc += field_width(ws, i);
        end
        return acc;
    endfunction

    function automatic int unsigned sum_widths(logic [WVEC_W-1:0] ws, int unsigned n);
        return field_offset(ws, n);
    endfunction

endpackage

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
    import pipe_bank_pkg::*;
(
    input  logic rst_i,
    input  logic stall_i,
    input  logic bubble_i,
    output act_e act_o
);

    // Reset and flush share one action; flush outranks hold
    always_comb begin
        if (rst_i || bubble_i) begin
            act_o = ACT_FLUSH;
        end else if (stall_i) begin
            act_o = ACT_HOLD;
        end else begin
            act_o = ACT_LOAD;
        end
    end

endmodule

// File: rtl/pipe_field.sv
module pipe_field
    import pipe_bank_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter logic [31:0] BUBBLE = 32'd0
) (
    input  act_e         act_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] q_i,
    output logic [W-1:0] nxt_o
);

    localparam logic [W-1:0] FLUSH_VAL = BUBBLE[W-1:0];

    always_comb begin
        case (act_i)
            ACT_LOAD:  nxt_o = d_i;
            ACT_HOLD:  nxt_o = q_i;
            ACT_FLUSH: nxt_o = FLUSH_VAL;
            default:   nxt_o = FLUSH_VAL;
        endcase
    end

endmodule

// File: rtl/pipe_stage_bank.sv
module pipe_stage_bank
    import pipe_bank_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 3,
    // Field i width in bits [8i+7:8i]
    parameter logic [WVEC_W-1:0] FIELD_W = WVEC_W'({8'd8, 8'd5, 8'd3}),
    // Field i flush constant in bits [32i+31:32i]
    parameter logic [BVEC_W-1:0] FIELD_BUBBLE = BVEC_W'({32'hA5, 32'd0, 32'd2}),
    localparam int unsigned TOTAL_W = sum_widths(FIELD_W, NUM_FIELDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall_i,
    input  logic               bubble_i,
    input  logic [TOTAL_W-1:0] fields_i,
    output logic [TOTAL_W-1:0] fields_o
);

    function automatic logic [TOTAL_W-1:0] build_bubble_vec();
        logic [TOTAL_W-1:0] v;
        v = '0;
        for (int unsigned f = 0; f < NUM_FIELDS; f++) begin
            for (int unsigned b = 0; b < 32; b++) begin
                if (b < field_width(FIELD_W, f)) begin
                    v[field_offset(FIELD_W, f) + b] = FIELD_BUBBLE[f*BSLOT_W + b];
                end
            end
        end
        return v;
    endfunction

    localparam logic [TOTAL_W-1:0] BUBBLE_VEC = build_bubble_vec();

    typedef struct packed {
        logic [TOTAL_W-1:0] data;
    } state_t;

    state_t             state_d;
    state_t             state_q;
    act_e               act;
    logic [TOTAL_W-1:0] nxt_bus;

    pipe_ctrl u_ctrl (
        .rst_i    (rst),
        .stall_i  (stall_i),
        .bubble_i (bubble_i),
        .act_o    (act)
    );

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int unsigned FW  = field_width(FIELD_W, f);
        localparam int unsigned OFF = field_offset(FIELD_W, f);

        pipe_field #(
            .W      (FW),
            .BUBBLE (FIELD_BUBBLE[f*BSLOT_W +: BSLOT_W])
        ) u_field (
            .act_i (act),
            .d_i   (fields_i[OFF +: FW]),
            .q_i   (state_q.data[OFF +: FW]),
            .nxt_o (nxt_bus[OFF +: FW])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.data = nxt_bus;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign fields_o = state_q.data;

endmodule

// File: rtl/pipe_stage_bank_chk.sv
module pipe_stage_bank_chk #(
    parameter int unsigned        TOTAL_W    = 16,
    parameter logic [TOTAL_W-1:0] BUBBLE_VEC = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               stall_i,
    input logic               bubble_i,
    input logic [TOTAL_W-1:0] fields_i,
    input logic [TOTAL_W-1:0] fields_o
);

    AST_RESET_FLUSH: assert property (@(posedge clk) rst |=> fields_o == BUBBLE_VEC); // R7

    AST_BUBBLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (bubble_i && !stall_i) |=> fields_o == BUBBLE_VEC); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !bubble_i) |=> $stable(fields_o)); // R4

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !bubble_i) |=> fields_o == $past(fields_i)); // R5

    AST_FLUSH_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (stall_i && bubble_i) |=> fields_o == BUBBLE_VEC); // R6

endmodule

bind pipe_stage_bank pipe_stage_bank_chk #(
    .TOTAL_W    (TOTAL_W),
    .BUBBLE_VEC (BUBBLE_VEC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall_i  (stall_i),
    .bubble_i (bubble_i),
    .fields_i (fields_i),
    .fields_o (fields_o)
);

// File: tb/pipe_stage_bank_test.sv
`timescale 1ns/100ps
module pipe_stage_bank_test;

    localparam int unsigned       W   = 16;
    localparam logic [W-1:0]      BUB = 16'hA502; // R2 flushed bus
    localparam int unsigned       MAX_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stall_i = 1'b0;
    logic         bubble_i = 1'b0;
    logic [W-1:0] fields_i = '0;
    logic [W-1:0] fields_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] model_q = BUB;

    always #2 clk = ~clk; // 250 MHz

    pipe_stage_bank uut (
        .clk      (clk),
        .rst      (rst),
        .stall_i  (stall_i),
        .bubble_i (bubble_i),
        .fields_i (fields_i),
        .fields_o (fields_o)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Driver: apply one edge of stimulus and push its expected outcome
    task automatic step(input logic r, input logic st, input logic bu,
                        input logic [W-1:0] d, input string tag);
        item_t it;
        @(negedge clk);
        rst      = r;
        stall_i  = st;
        bubble_i = bu;
        fields_i = d;
        if (r || bu)     model_q = BUB;
        else if (!st)    model_q = d;
        it.exp = model_q;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare one item per edge, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, fields_o, it.exp);
                if (it.tag == "R1") begin
                    check("R1 field0", {13'd0, fields_o[2:0]}, {13'd0, it.exp[2:0]});
                    check("R1 field1", {11'd0, fields_o[7:3]}, {11'd0, it.exp[7:3]});
                    check("R1 field2", {8'd0, fields_o[15:8]}, {8'd0, it.exp[15:8]});
                end
                if (it.tag == "R3") begin
                    check("R2 field0", {13'd0, fields_o[2:0]}, 16'd2);
                    check("R2 field1", {11'd0, fields_o[7:3]}, 16'd0);
                    check("R2 field2", {8'd0, fields_o[15:8]}, 16'h00A5);
                end
            end
        end
    end

    // Stimulus
    initial begin
        step(1, 0, 0, 16'hFFFF, "R7");
        step(1, 1, 0, 16'h1234, "R7");
        step(0, 0, 0, 16'h1234, "R1");
        step(0, 0, 0, 16'h0000, "R5");
        step(0, 0, 0, 16'hFFFF, "R1");
        step(0, 0, 0, 16'h5A5A, "R5");
        step(0, 1, 0, 16'hFFFF, "R4");
        step(0, 1, 0, 16'h0001, "R4");
        step(0, 1, 0, 16'h8000, "R4");
        step(0, 0, 1, 16'hFFFF, "R3");
        step(0, 0, 0, 16'h00F8, "R1");
        step(0, 0, 1, 16'h1234, "R3");
        step(0, 1, 1, 16'h7777, "R6");
        step(0, 0, 0, 16'hC3C3, "R5");
        step(0, 1, 1, 16'h0000, "R6");
        step(0, 1, 0, 16'h9999, "R4");
        step(0, 0, 0, 16'h2468, "R5");
        step(1, 1, 1, 16'hFFFF, "R7");
        step(0, 0, 0, 16'h0007, "R1");
        step(1, 0, 0, 16'h4321, "R7");
        step(0, 0, 0, 16'hBEEF, "R5");
        // R8: disturb the data bus between edges
        @(posedge clk);
        #1.5;
        fields_i = 16'h0F0F;
        #0.3;
        check("R8", fields_o, 16'hBEEF);
        step(0, 1, 0, 16'h1111, "R4");
        @(posedge clk);
        #1.5;
        fields_i = 16'hFFFF;
        #0.3;
        check("R8", fields_o, 16'hBEEF);
        step(0, 0, 0, 16'h0A0A, "R5");
        @(posedge clk);
        #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule